// File: doc/BRIEF.md
# Time-Slotted Interrupt Level Collector

The block recovers up to thirty-two interrupt levels from eight shared request lines. A source-side sequencer presents a different group of eight levels on the lines in each time slot and pulses a slot strobe at the end of each slot. A local slot counter tracks which group is on the lines. The number of groups in rotation is set by a two-bit multiplexing mode: one, two, three or four slots. The recovered levels are held in a 32-bit pending image, which software reads through a small register port.

The same port reaches a control register with three fields. A stop flag gates the clock enable of the downstream slave bus. A half-rate flag selects whether that bus runs at the full master-bus rate or at half of it. The half-rate flag can be cleared only once. The multiplexing mode is the third field.

Only a supervisor-qualified access may reach the pending image. Any other access to it returns zero and raises a one-cycle error pulse.

Top module: `irq_slot_collector`

## Requirements
- R1: After reset the control register reads 0x00000010 (stop 0, half-rate 1, mode 0), the pending image reads zero, `bus_clk_en` is 1 and `half_rate` is 1.
- R2: In mode 0 every slot strobe copies `irq_line[7:0]` into pending bits 7:0, and the slot counter stays at slot 0.
- R3: Each slot strobe captures line i of the current slot k into pending bit 8*k+i, then advances the slot counter. The counter wraps to slot 0 after slot `mode`, so it cycles through 2, 3 or 4 slots in modes 1, 2 and 3.
- R4: Pending bits for levels above 8*(mode+1)-1 read as 0. Lowering the mode clears the stored bits of the groups that leave the active range, so raising the mode again exposes zeros.
- R5: A control write that changes the mode returns the slot counter to slot 0. A slot strobe in that same cycle captures nothing.
- R6: Writes to the pending image (`reg_sel`=1) change none of its bits.
- R7: A read or write of the pending image with `reg_super`=0 returns 0 on `reg_rdata` (for a read) and drives `reg_err` high for exactly the following cycle. Any other access leaves `reg_err` low.
- R8: Control bit 0 is the stop flag. `bus_clk_en` is its inverse from the cycle after the write.
- R9: Control bit 4 is the half-rate flag, driven on `half_rate`. Writing 1 keeps it at 1 while it is still 1. Once a 0 has been written, later writes of 1 are ignored until reset.
- R10: Control bits 9:8 hold the mode. A read returns its data on `reg_rdata` in the cycle after `reg_rd`, and `reg_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 8 | Shared interrupt request lines |
| slot_stb | input | 1 | End-of-slot strobe; captures the lines and advances the slot |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_sel | input | 1 | Register select: 0 control, 1 pending image |
| reg_wdata | input | 32 | Write data |
| reg_super | input | 1 | Supervisor qualifier of the access |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| reg_err | output | 1 | One-cycle access-violation pulse |
| bus_clk_en | output | 1 | Slave-bus clock enable |
| half_rate | output | 1 | Slave-bus divide-by-two select |

## Verification
Several properties are checked on every cycle by the assertions:
- the slot counter never passes the slot count of the current mode and is back at slot 0 after a mode change;
- no pending bit above the active range is ever set;
- a strobe loads the current group with the sampled lines;
- the half-rate flag never rises once it is cleared;
- the error pulse follows only a non-supervisor access to the pending image.

Other properties need the bench's scenarios:
- the exact placement of levels across the rotation, and the wrap point of each mode;
- that lowering and then raising the mode exposes cleared groups;
- that pending writes leave the image unchanged;
- the register read values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // control register field positions
   localparam int CTRL_STOP_BIT = 0;
   localparam int CTRL_HALF_BIT = 4;
   localparam int CTRL_MODE_LSB = 8;

   // register select values
   localparam logic SEL_CTRL = 1'b0;
   localparam logic SEL_PEND = 1'b1;

   typedef enum logic [1:0] {
      MUX_ONE   = 2'd0,
      MUX_TWO   = 2'd1,
      MUX_THREE = 2'd2,
      MUX_FOUR  = 2'd3
   } mux_mode_e;

   // number of slots in rotation for a given mode value
   function automatic int slots_of(input int mode);
      return mode + 1;
   endfunction
endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg #(
   parameter int DATA_W = 32,
   parameter int SLOTS  = 4,
   localparam int MODE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              stop_q,
   output logic              half_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [MODE_W-1:0] mode_nxt,
   output logic              mode_chg
);
   import irqc_pkg::*;

   if (CTRL_MODE_LSB + MODE_W > DATA_W) begin : g_bad_width
      $error("irqc_ctrl_reg: mode field does not fit in DATA_W");
   end

   logic [MODE_W-1:0] mode_req;
   logic              mode_ok;
   logic              half_nxt;
   logic              stop_nxt;

   assign mode_req = wdata[CTRL_MODE_LSB +: MODE_W];
   assign mode_ok  = (int'(mode_req) < SLOTS);

   always_comb begin
      mode_nxt = mode_q;
      half_nxt = half_q;
      stop_nxt = stop_q;
      if (wr_en) begin
         stop_nxt = wdata[CTRL_STOP_BIT];
         // a cleared half-rate flag can never be set again
         half_nxt = half_q & wdata[CTRL_HALF_BIT];
         if (mode_ok) begin
            mode_nxt = mode_req;
         end
      end
   end

   assign mode_chg = (mode_nxt != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         half_q <= 1'b1;
         mode_q <= '0;
      end else begin
         stop_q <= stop_nxt;
         half_q <= half_nxt;
         mode_q <= mode_nxt;
      end
   end

   assert_half_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !half_q |=> !half_q)
      else $error("half-rate flag rose after being cleared");

   assert_mode_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(mode_q) < SLOTS)
      else $error("mode outside slot range");
endmodule

// File: rtl/irqc_slot_ctr.sv
module irqc_slot_ctr #(
   parameter int SLOTS = 4,
   localparam int MODE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              clear,
   input  logic [MODE_W-1:0] mode,
   output logic [MODE_W-1:0] slot_q
);
   logic last_slot;

   assign last_slot = (slot_q == mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (clear) begin
         slot_q <= '0;
      end else if (stb) begin
         if (last_slot) slot_q <= '0;
         else           slot_q <= slot_q + 1'b1;
      end
   end

   assert_slot_in_rotation_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(slot_q) <= int'(mode))
      else $error("slot counter beyond rotation length");

   assert_clear_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> slot_q == '0)
      else $error("slot counter not restarted by mode change");
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
   parameter int LINES  = 8,
   parameter int SLOTS  = 4,
   parameter int DATA_W = 32,
   localparam int MODE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int USED_W = LINES * SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  lines,
   input  logic              stb,
   input  logic [MODE_W-1:0] slot,
   input  logic [MODE_W-1:0] mode_q,
   input  logic [MODE_W-1:0] mode_nxt,
   output logic [DATA_W-1:0] pend
);
   if (USED_W > DATA_W) begin : g_bad_fit
      $error("irqc_pending: LINES*SLOTS exceeds DATA_W");
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_grp
      logic [LINES-1:0] grp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grp_q <= '0;
         end else if (int'(mode_nxt) < k) begin
            grp_q <= '0;
         end else if (stb && (slot == MODE_W'(k))) begin
            grp_q <= lines;
         end
      end

      assign pend[k*LINES +: LINES] = grp_q;

      assert_grp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (stb && slot == MODE_W'(k) && int'(mode_nxt) >= k) |=> grp_q == $past(lines))
         else $error("slot group did not load the lines");
   end

   if (USED_W < DATA_W) begin : g_pad
      assign pend[DATA_W-1:USED_W] = '0;
   end

   assert_above_range_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend >> (LINES * (int'(mode_q) + 1))) == '0)
      else $error("pending bit set above active range");
endmodule

// File: rtl/irq_slot_collector.sv
module irq_slot_collector #(
   parameter int LINES  = 8,
   parameter int SLOTS  = 4,
   parameter int DATA_W = 32,
   localparam int MODE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  irq_line,
   input  logic              slot_stb,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_super,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_err,
   output logic              bus_clk_en,
   output logic              half_rate
);
   import irqc_pkg::*;

   if (LINES < 1 || SLOTS < 2 || SLOTS > 4) begin : g_bad_param
      $error("irq_slot_collector: unsupported LINES/SLOTS");
   end

   logic              stop_q;
   logic              half_q;
   logic [MODE_W-1:0] mode_q;
   logic [MODE_W-1:0] mode_nxt;
   logic              mode_chg;
   logic [MODE_W-1:0] slot_q;
   logic [DATA_W-1:0] pend;
   logic [DATA_W-1:0] ctrl_img;
   logic              ctrl_wr;
   logic              stb_eff;
   logic              bad_access;

   assign ctrl_wr    = reg_wr && (reg_sel == SEL_CTRL);
   assign stb_eff    = slot_stb && !mode_chg;
   assign bad_access = (reg_rd || reg_wr) && (reg_sel == SEL_PEND) && !reg_super;

   irqc_ctrl_reg #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctrl_wr),
      .wdata    (reg_wdata),
      .stop_q   (stop_q),
      .half_q   (half_q),
      .mode_q   (mode_q),
      .mode_nxt (mode_nxt),
      .mode_chg (mode_chg)
   );

   irqc_slot_ctr #(.SLOTS(SLOTS)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (stb_eff),
      .clear  (mode_chg),
      .mode   (mode_q),
      .slot_q (slot_q)
   );

   irqc_pending #(.LINES(LINES), .SLOTS(SLOTS), .DATA_W(DATA_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (irq_line),
      .stb      (stb_eff),
      .slot     (slot_q),
      .mode_q   (mode_q),
      .mode_nxt (mode_nxt),
      .pend     (pend)
   );

   always_comb begin
      ctrl_img = '0;
      ctrl_img[CTRL_STOP_BIT] = stop_q;
      ctrl_img[CTRL_HALF_BIT] = half_q;
      ctrl_img[CTRL_MODE_LSB +: MODE_W] = mode_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         reg_err   <= 1'b0;
      end else begin
         reg_err <= bad_access;
         if (reg_rd) begin
            if (reg_sel == SEL_CTRL) reg_rdata <= ctrl_img;
            else if (reg_super)      reg_rdata <= pend;
            else                     reg_rdata <= '0;
         end
      end
   end

   assign bus_clk_en = !stop_q;
   assign half_rate  = half_q;

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> $past((reg_rd || reg_wr) && reg_sel && !reg_super))
      else $error("error pulse without a violating access");

   assert_denied_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel && !reg_super) |=> reg_rdata == '0)
      else $error("denied read returned data");

   assert_stop_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel) |=> bus_clk_en == !$past(reg_wdata[0]))
      else $error("clock enable does not follow stop write");

   assert_pend_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && !slot_stb && !mode_chg) |=> $stable(pend))
      else $error("pending image changed by a write");
endmodule

// File: tb/test_irq_slot_collector.sv
module test_irq_slot_collector;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_line = '0;
   logic        slot_stb = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_super = 1'b0;
   logic [31:0] reg_rdata;
   logic        reg_err;
   logic        bus_clk_en;
   logic        half_rate;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] data;
      logic        err;
      string       tag;
   } exp_t;
   exp_t exp_q[$];
   logic rd_seen_q = 1'b0;
   logic err_allowed_q = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_slot_collector i_irq_slot_collector (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .slot_stb(slot_stb),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_super(reg_super), .reg_rdata(reg_rdata), .reg_err(reg_err),
      .bus_clk_en(bus_clk_en), .half_rate(half_rate)
   );

   always @(posedge clk) begin
      rd_seen_q     <= reg_rd;
      err_allowed_q <= (reg_rd || reg_wr) && reg_sel && !reg_super;
   end

   // monitor: compare read results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_seen_q) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (reg_rdata !== e.data || reg_err !== e.err) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     e.tag, reg_rdata, reg_err, e.data, e.err);
         end
      end else if (rst_n && reg_err && !err_allowed_q) begin
         checks++;
         errors++;
         $display("FAIL R7: stray err=1 expected err=0");
      end
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic sel, input logic sup,
                          input logic [31:0] exp_d, input logic exp_e, input string tag);
      exp_t e;
      e.data = exp_d; e.err = exp_e; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = sel; reg_super = sup;
      @(negedge clk);
      reg_rd = 1'b0; reg_super = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_write(input logic sel, input logic sup, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_super = sup; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_super = 1'b0;
   endtask

   task automatic strobe(input logic [7:0] l);
      @(negedge clk);
      irq_line = l; slot_stb = 1'b1;
      @(negedge clk);
      slot_stb = 1'b0;
   endtask

   // control word: mode at bits 9:8, half-rate bit 4, stop bit 0
   function automatic logic [31:0] ctl(input int mode, input bit half, input bit stop);
      return (32'(mode) << 8) | (32'(half) << 4) | 32'(stop);
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(32'(bus_clk_en), 32'd1, "R1 bus_clk_en");
      check(32'(half_rate), 32'd1, "R1 half_rate");
      do_read(1'b0, 1'b0, 32'h0000_0010, 1'b0, "R1 ctrl reset");
      do_read(1'b1, 1'b1, 32'h0, 1'b0, "R1 pending reset");

      // R2 mode 0 direct mapping
      strobe(8'hA5);
      do_read(1'b1, 1'b1, 32'h0000_00A5, 1'b0, "R2 direct A5");
      strobe(8'h3C);
      do_read(1'b1, 1'b1, 32'h0000_003C, 1'b0, "R2 stays slot0");

      // R3 two-slot rotation
      do_write(1'b0, 1'b0, ctl(1, 1, 0));
      do_read(1'b0, 1'b0, ctl(1, 1, 0), 1'b0, "R10 ctrl mode field");
      do_read(1'b1, 1'b1, 32'h0000_003C, 1'b0, "R4 low group kept");
      strobe(8'h11); strobe(8'h22);
      do_read(1'b1, 1'b1, 32'h0000_2211, 1'b0, "R3 two slots");
      strobe(8'h33);
      do_read(1'b1, 1'b1, 32'h0000_2233, 1'b0, "R3 wrap after 2");

      // R3 four-slot rotation
      do_write(1'b0, 1'b0, ctl(3, 1, 0));
      strobe(8'h01); strobe(8'h02); strobe(8'h03); strobe(8'h04);
      do_read(1'b1, 1'b1, 32'h0403_0201, 1'b0, "R3 four slots");
      strobe(8'hFF);
      do_read(1'b1, 1'b1, 32'h0403_02FF, 1'b0, "R3 wrap after 4");

      // R4 lowering mode clears top group; R3 three-slot wrap
      do_write(1'b0, 1'b0, ctl(2, 1, 0));
      do_read(1'b1, 1'b1, 32'h0003_02FF, 1'b0, "R4 top group cleared");
      strobe(8'hAA); strobe(8'hBB); strobe(8'hCC);
      do_read(1'b1, 1'b1, 32'h00CC_BBAA, 1'b0, "R3 three slots");
      strobe(8'hDD);
      do_read(1'b1, 1'b1, 32'h00CC_BBDD, 1'b0, "R3 wrap after 3");

      // R5 mode change restarts at slot 0 (counter was at slot 1)
      do_write(1'b0, 1'b0, ctl(1, 1, 0));
      strobe(8'h77);
      do_read(1'b1, 1'b1, 32'h0000_BB77, 1'b0, "R5 restart slot0");
      // R4 raising mode exposes cleared groups
      do_write(1'b0, 1'b0, ctl(3, 1, 0));
      do_read(1'b1, 1'b1, 32'h0000_BB77, 1'b0, "R4 raised mode zeros");

      // R6 writes to pending have no effect
      do_write(1'b1, 1'b1, 32'hFFFF_FFFF);
      do_read(1'b1, 1'b1, 32'h0000_BB77, 1'b0, "R6 pending write inert");

      // R7 non-supervisor access
      do_read(1'b1, 1'b0, 32'h0, 1'b1, "R7 denied read");
      do_read(1'b0, 1'b0, ctl(3, 1, 0), 1'b0, "R7 ctrl read no err");
      do_write(1'b1, 1'b0, 32'h0);
      check(32'(reg_err), 32'd1, "R7 denied write err");
      @(negedge clk);
      check(32'(reg_err), 32'd0, "R7 err one cycle");

      // R9 half-rate write-once
      do_write(1'b0, 1'b0, ctl(3, 1, 0));
      check(32'(half_rate), 32'd1, "R9 write 1 while 1");
      do_write(1'b0, 1'b0, ctl(3, 0, 0));
      check(32'(half_rate), 32'd0, "R9 cleared");
      do_write(1'b0, 1'b0, ctl(3, 1, 0));
      check(32'(half_rate), 32'd0, "R9 set ignored");
      do_read(1'b0, 1'b0, ctl(3, 0, 0), 1'b0, "R9 ctrl shows locked");

      // R8 stop flag
      do_write(1'b0, 1'b0, ctl(3, 0, 1));
      check(32'(bus_clk_en), 32'd0, "R8 stopped");
      do_write(1'b0, 1'b0, ctl(3, 0, 0));
      check(32'(bus_clk_en), 32'd1, "R8 restarted");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule